// File: doc/BRIEF.md
# Local-Priority Dual-Port Memory Arbiter

This block shares one single-ported RAM between two masters: a local processor on the board and a requester on the system bus. The local side always comes first. As soon as the local processor signals that it wants the memory, the arbiter reserves the memory for it, before its read or write command arrives. Because of this early reservation, the only thing that can delay the local processor is a system cycle that had already started. That delay lasts at most one memory cycle.

Every memory access is a cycle of a fixed number of clocks. Ownership changes only between cycles. A system request waits until no local reservation is active. A local reservation that sits idle for too long yields to a waiting system request, so the system side cannot be starved. A bus-master mode input shuts the system port off completely, and all cycles then go to the local side. The arbiter drives the memory strobes (select, read, write, end-of-cycle) and a wait signal back to the local processor. Address steering and the RAM itself sit outside the block.

Top module: `lp_dpram_arb`

## Requirements
- R1: While reset is asserted, and in the first clock after it, all outputs are low and the memory is idle.
- R2: When the memory is idle, a high `loc_req` sets `loc_gnt` after the next rising edge, without starting a memory cycle. If `loc_req` and `sys_req` rise together, the local side gets the grant and `sys_gnt` stays low.
- R3: While a reservation is held, `loc_cmd` high starts a local cycle at the next edge. `mem_rd` is driven when `loc_we` was 0 at that edge, and `mem_wr` when it was 1.
- R4: Every memory cycle keeps `mem_sel` high for exactly CYC_CLKS clocks. `mem_done` is high only in the last of those clocks. Both grants hold steady until that clock.
- R5: When no reservation is active, a pending system request (`sys_req` high, bus-master mode off) starts a system cycle at the next boundary. `sys_gnt` stays high for the whole cycle. The direction comes from `sys_we` at the start edge: 0 means read, 1 means write.
- R6: `loc_wait` is high exactly when `loc_req` is high during a system cycle. It lasts at most CYC_CLKS clocks, and after it the local side holds `loc_gnt`.
- R7: If `loc_req` is still high when a local cycle ends, the reservation continues and a pending system request stays ungranted.
- R8: A reservation that stays idle while a system request is pending yields to that request. If the request is pending for the whole reservation, `sys_gnt` rises exactly HOLD_LIMIT clocks after `loc_gnt` rose.
- R9: With `master_mode` high, `sys_req` has no effect. `sys_gnt` stays low and no system cycle starts, while local reservations and cycles work as usual.
- R10: If `sys_req` stays high and there is no local request, system cycles follow one another with no idle clock between them.
- R11: `loc_gnt` and `sys_gnt` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = bus-master mode, system port disabled |
| loc_req | input | 1 | Local processor wants the memory (early reservation) |
| loc_cmd | input | 1 | Local read/write command present |
| loc_we | input | 1 | Local direction, 1 = write |
| sys_req | input | 1 | System-bus memory request, held until `sys_gnt` |
| sys_we | input | 1 | System direction, 1 = write |
| loc_gnt | output | 1 | Memory reserved for, or in use by, the local side |
| sys_gnt | output | 1 | System cycle in progress |
| mem_sel | output | 1 | RAM select during any cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_done | output | 1 | Last clock of the current cycle |
| loc_wait | output | 1 | Local processor must stall |

## Verification
The hardest case to reach is the reservation timeout. The local side must keep `loc_req` high without ever issuing a command, and a system request must be pending the whole time. The bench sets this up by raising both requests in the same clock from idle. The local side wins, and the bench then counts the clocks until `sys_gnt` rises, expecting exactly HOLD_LIMIT. The local stall bound is reached by raising `loc_req` during the first clock of a system cycle, which is the longest stall possible.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
   // Who owns the memory in the current clock
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,   // no owner, memory free
      OWN_RSV  = 2'd1,   // reserved for local, command not yet issued
      OWN_LCYC = 2'd2,   // local memory cycle running
      OWN_SCYC = 2'd3    // system memory cycle running
   } owner_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lpa_cycle_timer.sv
module lpa_cycle_timer #(
   parameter int unsigned CYC_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   output logic done
);
   localparam int unsigned CW = lpa_pkg::cnt_width(CYC_CLKS);
   localparam logic [CW-1:0] LAST = CW'(CYC_CLKS - 1);

   generate
      if (CYC_CLKS < 1) begin : g_bad
         $error("CYC_CLKS must be at least 1");
      end
      if (CYC_CLKS == 1) begin : g_single
         assign done = busy;
      end else begin : g_multi
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!busy || cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
         assign done = busy && (cnt == LAST);

         // R4
         cycle_runs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            busy && !done |=> busy);
      end
   endgenerate
endmodule

// File: rtl/lpa_hold_timer.sv
module lpa_hold_timer #(
   parameter int unsigned HOLD_LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic holding,
   output logic expired
);
   localparam int unsigned HW = lpa_pkg::cnt_width(HOLD_LIMIT);
   localparam logic [HW-1:0] LIM = HW'(HOLD_LIMIT - 1);

   generate
      if (HOLD_LIMIT < 2) begin : g_bad
         $error("HOLD_LIMIT must be at least 2");
      end
   endgenerate

   logic [HW-1:0] cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!holding)
         cnt <= '0;
      else if (cnt != LIM)
         cnt <= cnt + 1'b1;
   end
   assign expired = holding && (cnt == LIM);

   // R8
   hold_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expired && holding |=> !holding || expired);
endmodule

// File: rtl/lpa_owner_fsm.sv
module lpa_owner_fsm
   import lpa_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   master_mode,
   input  logic   loc_req,
   input  logic   loc_cmd,
   input  logic   loc_we,
   input  logic   sys_req,
   input  logic   sys_we,
   input  logic   cyc_done,
   input  logic   hold_expired,
   output owner_e owner,
   output logic   op_we
);
   owner_e nxt;
   logic   sys_ok;

   assign sys_ok = sys_req && !master_mode;

   always_comb begin
      nxt = owner;
      unique case (owner)
         OWN_IDLE: begin
            if (loc_req)      nxt = OWN_RSV;
            else if (sys_ok)  nxt = OWN_SCYC;
         end
         OWN_RSV: begin
            if (!loc_req)                    nxt = sys_ok ? OWN_SCYC : OWN_IDLE;
            else if (loc_cmd)                nxt = OWN_LCYC;
            else if (hold_expired && sys_ok) nxt = OWN_SCYC;
         end
         OWN_LCYC, OWN_SCYC: begin
            if (cyc_done) begin
               if (loc_req)      nxt = OWN_RSV;
               else if (sys_ok)  nxt = OWN_SCYC;
               else              nxt = OWN_IDLE;
            end
         end
         default: nxt = OWN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner <= OWN_IDLE;
         op_we <= 1'b0;
      end else begin
         owner <= nxt;
         if (nxt == OWN_LCYC && owner != OWN_LCYC)
            op_we <= loc_we;
         else if (nxt == OWN_SCYC && (owner != OWN_SCYC || cyc_done))
            op_we <= sys_we;
      end
   end

   // R2
   early_reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      owner == OWN_IDLE && loc_req |=> owner == OWN_RSV);
   // R9
   master_blocks_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
      master_mode && owner != OWN_SCYC |=> owner != OWN_SCYC);
   // R7
   local_keeps_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
      owner == OWN_LCYC && cyc_done && loc_req |=> owner == OWN_RSV);
endmodule

// File: rtl/lp_dpram_arb.sv
module lp_dpram_arb
   import lpa_pkg::*;
#(
   parameter int unsigned CYC_CLKS   = 4,
   parameter int unsigned HOLD_LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic master_mode,
   input  logic loc_req,
   input  logic loc_cmd,
   input  logic loc_we,
   input  logic sys_req,
   input  logic sys_we,
   output logic loc_gnt,
   output logic sys_gnt,
   output logic mem_sel,
   output logic mem_rd,
   output logic mem_wr,
   output logic mem_done,
   output logic loc_wait
);
   localparam int unsigned WW = cnt_width(CYC_CLKS + 2);
   localparam int unsigned RW = cnt_width(HOLD_LIMIT + 2);

   owner_e owner;
   logic   op_we;
   logic   cyc_busy;
   logic   cyc_done;
   logic   hold_expired;

   assign cyc_busy = (owner == OWN_LCYC) || (owner == OWN_SCYC);

   lpa_cycle_timer #(.CYC_CLKS(CYC_CLKS)) u_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (cyc_busy),
      .done  (cyc_done)
   );

   lpa_hold_timer #(.HOLD_LIMIT(HOLD_LIMIT)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .holding (owner == OWN_RSV),
      .expired (hold_expired)
   );

   lpa_owner_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .master_mode  (master_mode),
      .loc_req      (loc_req),
      .loc_cmd      (loc_cmd),
      .loc_we       (loc_we),
      .sys_req      (sys_req),
      .sys_we       (sys_we),
      .cyc_done     (cyc_done),
      .hold_expired (hold_expired),
      .owner        (owner),
      .op_we        (op_we)
   );

   assign loc_gnt  = (owner == OWN_RSV) || (owner == OWN_LCYC);
   assign sys_gnt  = (owner == OWN_SCYC);
   assign mem_sel  = cyc_busy;
   assign mem_rd   = cyc_busy && !op_we;
   assign mem_wr   = cyc_busy && op_we;
   assign mem_done = cyc_done;
   assign loc_wait = loc_req && sys_gnt;

   // Port-level checkers
   logic [WW-1:0] wait_run;
   logic [RW-1:0] rsv_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_run <= '0;
         rsv_run  <= '0;
      end else begin
         wait_run <= !loc_wait ? '0 :
                     (wait_run == WW'(CYC_CLKS + 1)) ? wait_run : wait_run + 1'b1;
         rsv_run  <= !(loc_gnt && !mem_sel && sys_req && !master_mode) ? '0 :
                     (rsv_run == RW'(HOLD_LIMIT + 1)) ? rsv_run : rsv_run + 1'b1;
      end
   end

   // R11
   grants_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_gnt && sys_gnt));
   // R6
   stall_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_run <= WW'(CYC_CLKS));
   // R8
   reserve_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_run <= RW'(HOLD_LIMIT));
   // R4
   grants_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel && !mem_done |=> mem_sel && $stable(loc_gnt) && $stable(sys_gnt));
   // R3
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}) && (mem_sel == (mem_rd || mem_wr)));
endmodule

// File: tb/lp_dpram_arb_tb.sv
module lp_dpram_arb_tb;
   localparam int unsigned CYC = 4;
   localparam int unsigned HOLD = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_mode = 1'b0, loc_req = 1'b0, loc_cmd = 1'b0, loc_we = 1'b0;
   logic sys_req = 1'b0, sys_we = 1'b0;
   logic loc_gnt, sys_gnt, mem_sel, mem_rd, mem_wr, mem_done, loc_wait;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   lp_dpram_arb #(.CYC_CLKS(CYC), .HOLD_LIMIT(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .loc_req(loc_req), .loc_cmd(loc_cmd), .loc_we(loc_we),
      .sys_req(sys_req), .sys_we(sys_we),
      .loc_gnt(loc_gnt), .sys_gnt(sys_gnt), .mem_sel(mem_sel),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_done(mem_done), .loc_wait(loc_wait)
   );

   function automatic logic [6:0] outs();
      return {loc_gnt, sys_gnt, mem_sel, mem_rd, mem_wr, mem_done, loc_wait};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // inputs {mode, loc_req, loc_cmd, loc_we, sys_req, sys_we}
   // outputs {loc_gnt, sys_gnt, sel, rd, wr, done, wait}
   localparam int NV = 15;
   localparam logic [12:0] VEC [NV] = '{
      {6'b000000, 7'b0000000},   // idle
      {6'b000011, 7'b0110100},   // R5 system write starts
      {6'b010000, 7'b0110101},   // R6 local stalls
      {6'b010000, 7'b0110101},
      {6'b010000, 7'b0110111},   // R4 done
      {6'b010000, 7'b1000000},   // R6 reservation after stall
      {6'b011000, 7'b1011000},   // R3 local read
      {6'b010010, 7'b1011000},
      {6'b010010, 7'b1011000},
      {6'b010010, 7'b1011010},
      {6'b000010, 7'b0111000},   // R5 system read
      {6'b000000, 7'b0111000},
      {6'b000000, 7'b0111000},
      {6'b000000, 7'b0111010},
      {6'b000000, 7'b0000000}
   };

   initial begin
      #1_000_000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int k;
      int dones;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 outputs in reset", 32'(outs()), 32'h0);
      rst_n = 1'b1;
      tick();
      check("R1 outputs after reset", 32'(outs()), 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         {master_mode, loc_req, loc_cmd, loc_we, sys_req, sys_we} = VEC[i][12:7];
         tick();
         check($sformatf("R4 R5 R6 R3 vector %0d", i), 32'(outs()), 32'(VEC[i][6:0]));
      end

      // R2 / R11 simultaneous requests, then R8 timeout
      loc_req = 1'b1; sys_req = 1'b1; sys_we = 1'b0;
      tick();
      check("R2 local wins grant", 32'(loc_gnt), 32'h1);
      check("R11 system not granted", 32'(sys_gnt), 32'h0);
      check("R2 no cycle on reservation", 32'(mem_sel), 32'h0);
      k = 0;
      while (!sys_gnt && k < 50) begin
         tick();
         k++;
      end
      check("R8 yield after HOLD_LIMIT clocks", 32'(k), 32'(HOLD));
      check("R6 local waits in yielded cycle", 32'(loc_wait), 32'h1);
      sys_req = 1'b0;
      k = 0;
      while (!loc_gnt && k < 50) begin
         tick();
         k++;
      end
      check("R6 stall length", 32'(k), 32'(CYC));
      check("R6 wait drops with grant", 32'(loc_wait), 32'h0);
      loc_req = 1'b0;
      tick();
      check("R2 release to idle", 32'(outs()), 32'h0);

      // R9 bus-master mode
      master_mode = 1'b1; sys_req = 1'b1;
      k = 0;
      for (int i = 0; i < 10; i++) begin
         tick();
         if (sys_gnt || mem_sel) k++;
      end
      check("R9 system ignored", 32'(k), 32'h0);
      loc_req = 1'b1;
      tick();
      check("R9 local reserve in master mode", 32'(loc_gnt), 32'h1);
      loc_cmd = 1'b1; loc_we = 1'b1;
      tick();
      loc_cmd = 1'b0;
      check("R3 local write strobe", 32'({mem_sel, mem_wr, mem_rd}), 32'b110);
      repeat (CYC - 1) tick();
      check("R3 local cycle done", 32'(mem_done), 32'h1);
      loc_req = 1'b0;
      tick();
      check("R9 idle after local", 32'(outs()), 32'h0);
      master_mode = 1'b0;
      tick();
      check("R5 pending served when mode off", 32'(sys_gnt), 32'h1);

      // R10 back-to-back system cycles
      dones = 0;
      for (int i = 0; i < CYC; i++) begin
         if (mem_done) dones++;
         tick();
      end
      check("R10 second cycle follows at once", 32'({sys_gnt, mem_sel}), 32'b11);
      check("R10 one done in first cycle", 32'(dones), 32'h1);
      sys_req = 1'b0;
      repeat (CYC) tick();
      check("R10 idle after requests end", 32'(outs()), 32'h0);

      // R7 local keeps memory after its cycle
      loc_req = 1'b1; loc_cmd = 1'b1; loc_we = 1'b0;
      tick();
      tick();
      loc_cmd = 1'b0; sys_req = 1'b1;
      repeat (CYC - 1) tick();
      check("R7 local done", 32'({mem_done, mem_rd}), 32'b11);
      tick();
      check("R7 reservation kept", 32'({loc_gnt, sys_gnt, mem_sel}), 32'b100);
      loc_req = 1'b0;
      tick();
      check("R5 system after release", 32'(sys_gnt), 32'h1);

      // R1 reset in mid-cycle
      rst_n = 1'b0;
      #1;
      check("R1 mid-cycle reset", 32'(outs()), 32'h0);
      sys_req = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      check("R1 idle after reset", 32'(outs()), 32'h0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule